// File: doc/BRIEF.md
# Synchronous Serial Port Register and Interrupt File

This block is the software-visible front end of a synchronous serial port. A processor reaches it over a plain 32-bit register bus (address, write strobe, read strobe, write data, combinational read data). It keeps the frame and mode configuration, the clock prescale divisor, the interrupt mask and the DMA enables, and it drives all of them to a serial shifter that lives outside the block.

Two 8-deep queues of 16-bit words sit between the bus and the shifter. A bus write to the data word queues a word for transmission. A bus read of the data word takes the oldest received word. The shifter takes transmit words through a pop strobe and delivers received words through a push strobe. The block reports queue state as status flags, as sticky and level interrupt sources, as a masked view with a single interrupt line, and as one DMA request per direction.

Top module: `ssp_regfile`

## Requirements
- R1: After reset, frame control and mode control read 0, prescale reads 2, mask and DMA control read 0, status reads 0x03, raw interrupt status reads 0x08 and masked status reads 0.
- R2: Frame control (byte offset 0x00) keeps write data bits [15:0] and mode control (0x04) keeps bits [3:0]. Both read back those bits with the upper bits zero, and both drive the shifter configuration outputs.
- R3: Prescale (0x10) stores the low 8 bits of a write with bit 0 cleared, and a result of 0 becomes 2. It never holds an odd value or zero.
- R4: A write to the data word (0x08) appends bits [15:0] to the transmit queue unless it already holds 8 words, in which case the write is dropped. The shifter sees the oldest word on `tx_word`, qualified by `tx_valid`, and removes it with `tx_pop`.
- R5: Status (0x0C) is read-only: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy.
- R6: A read of the data word removes and returns the oldest received word, zero-extended. When the receive queue is empty it returns 0 and changes nothing.
- R7: A received word that arrives while the receive queue holds 8 words is discarded and sets the sticky overrun flag (raw bit 0).
- R8: Raw interrupt status (0x18) is read-only: bit 0 overrun, bit 1 receive timeout, bit 2 set while the receive queue holds 4 or more words, bit 3 set while the transmit queue holds 4 or fewer words.
- R9: Mask (0x14) keeps bits [3:0] with the same bit order as raw status. Masked status (0x1C) reads as raw AND mask, and `irq` is high when any masked bit is set.
- R10: A write to the clear word (0x20) clears raw bit 0 where write bit 0 is 1 and raw bit 1 where write bit 1 is 1. Other bits have no effect, and the clear word reads 0.
- R11: DMA control (0x24) keeps bit 0 receive enable and bit 1 transmit enable. `dma_tx_req` is high when transmit is enabled and the transmit queue is not full. `dma_rx_req` is high when receive is enabled and the receive queue is not empty.
- R12: A `rx_timeout` pulse sets the sticky timeout flag (raw bit 1), and it stays set until cleared.
- R13: Busy (status bit 4) is high when `shifter_busy` is high or the transmit queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (required for the data-word pop) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| cfg_frame | output | 16 | Frame control to the shifter |
| cfg_mode | output | 4 | Mode control to the shifter |
| cfg_prescale | output | 8 | Prescale divisor to the shifter |
| tx_word | output | 16 | Oldest queued transmit word |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_pop | input | 1 | Shifter takes the transmit word |
| rx_word | input | 16 | Received word from the shifter |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_timeout | input | 1 | Receive timeout event from the shifter |
| shifter_busy | input | 1 | Shifter is moving a frame |
| irq | output | 1 | OR of the masked interrupt bits |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
Register writes are tried with all-ones patterns, with patterns that have bits set above the stored field, and with odd, zero and over-range prescale values. These tell a correct field mask apart from a full-width store or a missing even/clamp rule. The queues are filled one word at a time across both level thresholds and past full. That separates an off-by-one threshold from a correct one and a dropped overflow word from a stored one. The interrupt tests clear with bits that must be ignored and then with the real bits, so an over-wide clear cannot pass. Distinct ramps in each direction expose any reordering or word loss.

// File: rtl/ssp_regfile.sv
module ssp_regfile #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int PSW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [15:0]   cfg_frame,
  output logic [3:0]    cfg_mode,
  output logic [PSW-1:0] cfg_prescale,
  output logic [DW-1:0] tx_word,
  output logic          tx_valid,
  input  logic          tx_pop,
  input  logic [DW-1:0] rx_word,
  input  logic          rx_push,
  input  logic          rx_timeout,
  input  logic          shifter_busy,
  output logic          irq,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int PW   = $clog2(DEPTH);
  localparam int HALF = DEPTH / 2;
  localparam logic [AW-3:0] IX_FRM  = (AW-2)'(0);
  localparam logic [AW-3:0] IX_MODE = (AW-2)'(1);
  localparam logic [AW-3:0] IX_DATA = (AW-2)'(2);
  localparam logic [AW-3:0] IX_STAT = (AW-2)'(3);
  localparam logic [AW-3:0] IX_PSC  = (AW-2)'(4);
  localparam logic [AW-3:0] IX_MASK = (AW-2)'(5);
  localparam logic [AW-3:0] IX_RAW  = (AW-2)'(6);
  localparam logic [AW-3:0] IX_MSK  = (AW-2)'(7);
  localparam logic [AW-3:0] IX_CLR  = (AW-2)'(8);
  localparam logic [AW-3:0] IX_DMA  = (AW-2)'(9);

  logic [AW-3:0] widx;
  logic          aligned;
  assign widx    = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  logic wsel_frm, wsel_mode, wsel_data, wsel_psc, wsel_mask, wsel_clr, wsel_dma, rsel_data;
  assign wsel_frm  = bus_wr && aligned && widx == IX_FRM;
  assign wsel_mode = bus_wr && aligned && widx == IX_MODE;
  assign wsel_data = bus_wr && aligned && widx == IX_DATA;
  assign wsel_psc  = bus_wr && aligned && widx == IX_PSC;
  assign wsel_mask = bus_wr && aligned && widx == IX_MASK;
  assign wsel_clr  = bus_wr && aligned && widx == IX_CLR;
  assign wsel_dma  = bus_wr && aligned && widx == IX_DMA;
  assign rsel_data = bus_rd && aligned && widx == IX_DATA;

  logic [15:0]    frm_q;
  logic [3:0]     mode_q;
  logic [PSW-1:0] psc_q;
  logic [3:0]     mask_q;
  logic [1:0]     dma_q;
  logic           ovr_q, to_q;

  logic [PSW-1:0] psc_even;
  assign psc_even = bus_wdata[PSW-1:0] & ~PSW'(1);

  wire unused_bits = ^{bus_wdata[31:16]};

  // transmit queue
  logic [DW-1:0] tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_in, tx_out, tx_full, tx_empty;
  assign tx_full  = (tx_cnt == CW'(DEPTH));
  assign tx_empty = (tx_cnt == '0);
  assign tx_in    = wsel_data && !tx_full;
  assign tx_out   = tx_pop && !tx_empty;

  // receive queue
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_in, rx_out, rx_full, rx_empty, ovr_ev;
  assign rx_full  = (rx_cnt == CW'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign rx_in    = rx_push && !rx_full;
  assign ovr_ev   = rx_push && rx_full;
  assign rx_out   = rsel_data && !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q  <= '0;
      mode_q <= '0;
      psc_q  <= PSW'(2);
      mask_q <= '0;
      dma_q  <= '0;
    end else begin
      if (wsel_frm)  frm_q  <= bus_wdata[15:0];
      if (wsel_mode) mode_q <= bus_wdata[3:0];
      if (wsel_psc)  psc_q  <= (psc_even == '0) ? PSW'(2) : psc_even;
      if (wsel_mask) mask_q <= bus_wdata[3:0];
      if (wsel_dma)  dma_q  <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (ovr_ev)                      ovr_q <= 1'b1;
      else if (wsel_clr && bus_wdata[0]) ovr_q <= 1'b0;
      if (rx_timeout)                  to_q  <= 1'b1;
      else if (wsel_clr && bus_wdata[1]) to_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (tx_in)  tx_wp <= tx_wp + PW'(1);
      if (tx_out) tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
      if (rx_in)  rx_wp <= rx_wp + PW'(1);
      if (rx_out) rx_rp <= rx_rp + PW'(1);
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_in) tx_mem[tx_wp] <= bus_wdata[DW-1:0];
    if (rx_in) rx_mem[rx_wp] <= rx_word;
  end

  logic [4:0] stat;
  logic [3:0] raw, masked;
  assign stat   = {shifter_busy || !tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};
  assign raw    = {tx_cnt <= CW'(HALF), rx_cnt >= CW'(HALF), to_q, ovr_q};
  assign masked = raw & mask_q;

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (widx)
        IX_FRM:  bus_rdata = {16'h0, frm_q};
        IX_MODE: bus_rdata = {28'h0, mode_q};
        IX_DATA: bus_rdata = rx_empty ? 32'h0 : 32'(rx_mem[rx_rp]);
        IX_STAT: bus_rdata = {27'h0, stat};
        IX_PSC:  bus_rdata = 32'(psc_q);
        IX_MASK: bus_rdata = {28'h0, mask_q};
        IX_RAW:  bus_rdata = {28'h0, raw};
        IX_MSK:  bus_rdata = {28'h0, masked};
        IX_DMA:  bus_rdata = {30'h0, dma_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign cfg_frame    = frm_q;
  assign cfg_mode     = mode_q;
  assign cfg_prescale = psc_q;
  assign tx_word      = tx_mem[tx_rp];
  assign tx_valid     = !tx_empty;
  assign irq          = |masked;
  assign dma_tx_req   = dma_q[1] && !tx_full;
  assign dma_rx_req   = dma_q[0] && !rx_empty;
endmodule

// File: rtl/ssp_regfile_sva.sv
module ssp_regfile_sva #(
  parameter int AW    = 8,
  parameter int DEPTH = 8,
  parameter int PSW   = 8,
  parameter int CW    = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [AW-3:0]  addr_word,
  input logic [1:0]     clr_bits,
  input logic           rx_push,
  input logic           tx_pop,
  input logic [CW-1:0]  tx_cnt,
  input logic [CW-1:0]  rx_cnt,
  input logic [PSW-1:0] psc_q,
  input logic           ovr_q,
  input logic           to_q,
  input logic           dma_rx_req
);
  logic clr_hit;
  assign clr_hit = bus_wr && addr_word == (AW-2)'(8);

  a_r3_prescale_even: assert property (@(posedge clk) disable iff (!rst_n)
    !psc_q[0] && psc_q != '0);

  a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt == CW'(DEPTH) && !tx_pop |=> tx_cnt == CW'(DEPTH));

  a_r6_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

  a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_cnt == CW'(DEPTH) |=> ovr_q);

  a_r10_clear_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit && clr_bits[0] && !(rx_push && rx_cnt == CW'(DEPTH)) |=> !ovr_q);

  a_r12_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    to_q && !(clr_hit && clr_bits[1]) |=> to_q);

  a_r11_dma_rx: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> rx_cnt != '0);
endmodule

bind ssp_regfile ssp_regfile_sva #(.AW(AW), .DEPTH(DEPTH), .PSW(PSW), .CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .addr_word(bus_addr[AW-1:2]),
  .clr_bits(bus_wdata[1:0]), .rx_push(rx_push), .tx_pop(tx_pop),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .psc_q(psc_q), .ovr_q(ovr_q), .to_q(to_q),
  .dma_rx_req(dma_rx_req)
);

// File: tb/ssp_regfile_tb.sv
module ssp_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] cfg_frame;
  logic [3:0]  cfg_mode;
  logic [7:0]  cfg_prescale;
  logic [15:0] tx_word;
  logic        tx_valid;
  logic        tx_pop = 1'b0;
  logic [15:0] rx_word = '0;
  logic        rx_push = 1'b0, rx_timeout = 1'b0, shifter_busy = 1'b0;
  logic        irq, dma_tx_req, dma_rx_req;

  int total = 0, failed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ssp_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_frame(cfg_frame), .cfg_mode(cfg_mode),
    .cfg_prescale(cfg_prescale), .tx_word(tx_word), .tx_valid(tx_valid), .tx_pop(tx_pop),
    .rx_word(rx_word), .rx_push(rx_push), .rx_timeout(rx_timeout), .shifter_busy(shifter_busy),
    .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  localparam logic [7:0] A_FRM = 8'h00, A_MODE = 8'h04, A_DATA = 8'h08, A_STAT = 8'h0C,
                         A_PSC = 8'h10, A_MASK = 8'h14, A_RAW = 8'h18, A_MSK = 8'h1C,
                         A_CLR = 8'h20, A_DMA = 8'h24;

  // {addr, write data, expected readback, requirement number}
  localparam int NV = 16;
  localparam logic [79:0] VEC [NV] = '{
    {A_FRM,  32'hFFFF_ABCD, 32'h0000_ABCD, 8'd2},  // R2
    {A_FRM,  32'h0000_0047, 32'h0000_0047, 8'd2},  // R2
    {A_MODE, 32'hFFFF_FFFA, 32'h0000_000A, 8'd2},  // R2
    {A_MODE, 32'h0000_0000, 32'h0000_0000, 8'd2},  // R2
    {A_PSC,  32'h0000_0037, 32'h0000_0036, 8'd3},  // R3
    {A_PSC,  32'h0000_0001, 32'h0000_0002, 8'd3},  // R3
    {A_PSC,  32'h0000_0000, 32'h0000_0002, 8'd3},  // R3
    {A_PSC,  32'h0000_01FF, 32'h0000_00FE, 8'd3},  // R3
    {A_MASK, 32'h0000_00FF, 32'h0000_000F, 8'd9},  // R9
    {A_MASK, 32'h0000_0000, 32'h0000_0000, 8'd9},  // R9
    {A_DMA,  32'h0000_00FF, 32'h0000_0003, 8'd11}, // R11
    {A_DMA,  32'h0000_0000, 32'h0000_0000, 8'd11}, // R11
    {A_STAT, 32'h0000_FFFF, 32'h0000_0003, 8'd5},  // R5
    {A_RAW,  32'h0000_000F, 32'h0000_0008, 8'd8},  // R8
    {A_MSK,  32'h0000_000F, 32'h0000_0000, 8'd9},  // R9
    {A_CLR,  32'h0000_000F, 32'h0000_0000, 8'd10}  // R10
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic push_rx(input logic [15:0] w);
    @(negedge clk);
    rx_word = w; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdchk("R1 frame",    A_FRM,  32'h0);
    rdchk("R1 mode",     A_MODE, 32'h0);
    rdchk("R1 prescale", A_PSC,  32'h2);
    rdchk("R1 mask",     A_MASK, 32'h0);
    rdchk("R1 dma",      A_DMA,  32'h0);
    rdchk("R1 status",   A_STAT, 32'h03);
    rdchk("R1 raw",      A_RAW,  32'h08);
    rdchk("R1 masked",   A_MSK,  32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][79:72], v);
      total++;
      if (v !== VEC[i][39:8]) begin
        failed++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i][7:0], i, v, VEC[i][39:8]);
      end
    end
    chk("R2 cfg_frame", 32'(cfg_frame), 32'h0047);
    chk("R3 cfg_prescale", 32'(cfg_prescale), 32'h00FE);

    // R4 / R8 / R11 / R13 transmit fill
    wr(A_DMA, 32'h2);
    chk("R11 dma_tx_req empty", 32'(dma_tx_req), 32'h1);
    for (int i = 0; i < 8; i++) begin
      wr(A_DATA, 32'hFFFF_1000 + 32'(i));
      if (i == 3) rdchk("R8 tx level at 4", A_RAW, 32'h08);
      if (i == 4) rdchk("R8 tx level at 5", A_RAW, 32'h00);
    end
    rdchk("R5 R13 status tx full", A_STAT, 32'h10);
    chk("R11 dma_tx_req full", 32'(dma_tx_req), 32'h0);
    wr(A_DATA, 32'h0000_DEAD);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R4 tx_valid", 32'(tx_valid), 32'h1);
      chk("R4 tx order", 32'(tx_word), 32'h1000 + 32'(i));
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
    end
    @(negedge clk);
    chk("R4 overflow word dropped", 32'(tx_valid), 32'h0);
    shifter_busy = 1'b1;
    rdchk("R13 busy from shifter", A_STAT, 32'h13);
    shifter_busy = 1'b0;
    rdchk("R13 idle", A_STAT, 32'h03);

    // R6 / R7 / R8 / R9 / R10 / R11 receive
    wr(A_DMA, 32'h1);
    chk("R11 dma_rx_req empty", 32'(dma_rx_req), 32'h0);
    for (int i = 0; i < 8; i++) begin
      push_rx(16'h2000 + 16'(i));
      if (i == 0) chk("R11 dma_rx_req", 32'(dma_rx_req), 32'h1);
      if (i == 2) rdchk("R8 rx level at 3", A_RAW, 32'h08);
      if (i == 3) rdchk("R8 rx level at 4", A_RAW, 32'h0C);
    end
    rdchk("R5 status rx full", A_STAT, 32'h0F);
    push_rx(16'hBEEF);
    rdchk("R7 overrun set", A_RAW, 32'h0D);
    wr(A_MASK, 32'h1);
    rdchk("R9 masked overrun", A_MSK, 32'h1);
    chk("R9 irq on", 32'(irq), 32'h1);
    wr(A_MASK, 32'h0);
    chk("R9 irq masked off", 32'(irq), 32'h0);
    wr(A_CLR, 32'hC);
    rdchk("R10 other bits ignored", A_RAW, 32'h0D);
    wr(A_CLR, 32'h1);
    rdchk("R10 overrun cleared", A_RAW, 32'h0C);
    for (int i = 0; i < 8; i++) begin
      rdchk("R6 R7 rx order", A_DATA, 32'h2000 + 32'(i));
      if (i == 3) rdchk("R8 rx level 4 left", A_RAW, 32'h0C);
      if (i == 4) rdchk("R8 rx level 3 left", A_RAW, 32'h08);
    end
    rdchk("R6 empty read", A_DATA, 32'h0);
    rdchk("R6 status after drain", A_STAT, 32'h03);
    chk("R11 dma_rx_req drained", 32'(dma_rx_req), 32'h0);

    // R12 timeout
    @(negedge clk); rx_timeout = 1'b1;
    @(negedge clk); rx_timeout = 1'b0;
    repeat (3) @(negedge clk);
    rdchk("R12 timeout sticky", A_RAW, 32'h0A);
    wr(A_MASK, 32'h2);
    chk("R9 R12 irq timeout", 32'(irq), 32'h1);
    wr(A_CLR, 32'h2);
    rdchk("R10 timeout cleared", A_RAW, 32'h08);
    chk("R10 irq cleared", 32'(irq), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule